// File: doc/BRIEF.md
# Sub-dword operand select and insert unit

This unit carries out one lane of a two-operand vector ALU instruction in which each operand, and the destination, may address only part of a 32-bit word. For each source, a 3-bit field code picks one of the four bytes, one of the two 16-bit halves, or the full word. The picked field is widened back to the full word width, by zero or by sign extension according to a per-source flag.

A small ALU (XOR, ADD, AND) combines the two widened values. A destination field code then chooses where the low bits of the ALU result are written inside the destination word. A 2-bit fill mode decides what the other bits of the destination become, and the previous destination word is supplied as an input for that purpose.

The result is registered. It appears, together with a valid flag, on the clock edge after an input marked valid. Instruction decode and register storage are handled elsewhere.

Top module: `subdw_sel_unit`

## Requirements
- R1: Field codes are shared by both sources and the destination. Code 0 selects bits 7:0, 1 selects bits 15:8, 2 selects bits 23:16 and 3 selects bits 31:24. Code 4 selects bits 15:0, 5 selects bits 31:16, and 6 selects the full 32-bit word.
- R2: With its extend flag at 0, a source field of a byte or half is zero-extended to 32 bits before the ALU.
- R3: With its extend flag at 1, a source field of a byte or half is sign-extended to 32 bits before the ALU, copying the field's top bit.
- R4: Source code 6 passes the operand through unchanged whatever its extend flag. Reserved code 7 behaves exactly like code 6, for sources and for the destination.
- R5: The operation code selects the ALU function: 0 gives XOR, 1 gives ADD modulo 2^32, 2 gives AND, and reserved code 3 behaves as XOR. The ALU always works on the two widened source values.
- R6: The ALU result, truncated to the width of the destination field, is placed at that field's bit position. With destination code 6 or 7, the whole 32-bit result is written and the fill mode has no effect.
- R7: Fill mode 0 clears every destination bit outside the written field.
- R8: Fill mode 1 sets the destination bits above the written field to a copy of the field's top bit and clears the bits below it.
- R9: Fill mode 2 keeps the previous destination bits outside the written field. Reserved fill mode 3 behaves as mode 0.
- R10: `out_valid` equals `in_valid` of the previous cycle. `result` updates only on the edge after a valid input and holds its value otherwise.
- R11: While `rst` is high at a clock edge, `out_valid` and `result` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs carry an operation this cycle |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| sel_a | input | 3 | Field code for the first source |
| sel_b | input | 3 | Field code for the second source |
| sext_a | input | 1 | Sign-extend the first source field |
| sext_b | input | 1 | Sign-extend the second source field |
| alu_op | input | 2 | ALU function code |
| dst_sel | input | 3 | Field code for the destination |
| fill_mode | input | 2 | Policy for destination bits outside the field |
| dst_old | input | 32 | Destination word before the operation |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 32 | Registered destination word |

## Verification
The bench builds the unit with the default 32-bit word. At that width every field code maps onto a real byte or half, so the top edge of byte 3 and half 1 is reached. Sign extension is exercised from bit 7 and from bit 15, and the ADD carry out of bit 31 can be checked for wrap-around. Directed vectors cover each source, destination and fill code, including both reserved codes. A random stream with gaps in `in_valid` is then compared every cycle against a behavioural model.

// File: rtl/subdw_pkg.sv
`timescale 1ns/1ps
package subdw_pkg;
  typedef enum logic [2:0] {
    FS_B0  = 3'd0,
    FS_B1  = 3'd1,
    FS_B2  = 3'd2,
    FS_B3  = 3'd3,
    FS_H0  = 3'd4,
    FS_H1  = 3'd5,
    FS_DW  = 3'd6,
    FS_RSV = 3'd7
  } fsel_e;

  typedef enum logic [1:0] {
    OP_XOR = 2'd0,
    OP_ADD = 2'd1,
    OP_AND = 2'd2,
    OP_RSV = 2'd3
  } aluop_e;

  typedef enum logic [1:0] {
    FILL_ZERO = 2'd0,
    FILL_SIGN = 2'd1,
    FILL_KEEP = 2'd2,
    FILL_RSV  = 2'd3
  } fill_e;
endpackage

// File: rtl/subdw_extract.sv
`timescale 1ns/1ps
module subdw_extract #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] din,
  input  logic [2:0]    sel,
  input  logic          sext,
  output logic [DW-1:0] dout
);
  import subdw_pkg::*;
  localparam int LW = DW / 4;
  localparam int HW = DW / 2;

  logic [3:0][LW-1:0] bsl;
  logic [1:0][HW-1:0] hsl;

  genvar k;
  generate
    for (k = 0; k < 4; k++) begin : g_byte
      assign bsl[k] = din[k*LW +: LW];
    end
    for (k = 0; k < 2; k++) begin : g_half
      assign hsl[k] = din[k*HW +: HW];
    end
  endgenerate

  // Byte codes, then half codes; codes 6 and 7 fall through unchanged.
  always_comb begin
    dout = din;
    if (sel < 3'(FS_H0)) begin
      dout = {{(DW-LW){sext & bsl[sel[1:0]][LW-1]}}, bsl[sel[1:0]]};
    end else if (sel < 3'(FS_DW)) begin
      dout = {{(DW-HW){sext & hsl[sel[0]][HW-1]}}, hsl[sel[0]]};
    end
  end
endmodule

// File: rtl/subdw_alu.sv
`timescale 1ns/1ps
module subdw_alu #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic [1:0]    op,
  output logic [DW-1:0] res
);
  import subdw_pkg::*;

  always_comb begin
    case (aluop_e'(op))
      OP_ADD:  res = opa + opb;
      OP_AND:  res = opa & opb;
      default: res = opa ^ opb;   // OP_XOR and the reserved code
    endcase
  end
endmodule

// File: rtl/subdw_insert.sv
`timescale 1ns/1ps
module subdw_insert #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] res,
  input  logic [DW-1:0] old,
  input  logic [2:0]    dsel,
  input  logic [1:0]    fill,
  output logic [DW-1:0] dout
);
  import subdw_pkg::*;
  localparam int LW   = DW / 4;
  localparam int HW   = DW / 2;
  localparam int OFFW = $clog2(DW);

  logic [DW-1:0]   zx;
  logic [DW-1:0]   sx;
  logic [DW-1:0]   fm;
  logic [OFFW-1:0] off;

  // Field width, position and mask, then shift into place.
  always_comb begin
    zx  = res;
    sx  = res;
    fm  = '1;
    off = '0;
    if (dsel < 3'(FS_H0)) begin
      zx  = {{(DW-LW){1'b0}}, res[LW-1:0]};
      sx  = {{(DW-LW){res[LW-1]}}, res[LW-1:0]};
      fm  = {{(DW-LW){1'b0}}, {LW{1'b1}}};
      off = OFFW'(int'(dsel[1:0]) * LW);
    end else if (dsel < 3'(FS_DW)) begin
      zx  = {{(DW-HW){1'b0}}, res[HW-1:0]};
      sx  = {{(DW-HW){res[HW-1]}}, res[HW-1:0]};
      fm  = {{(DW-HW){1'b0}}, {HW{1'b1}}};
      off = OFFW'(int'(dsel[0]) * HW);
    end
  end

  always_comb begin
    case (fill_e'(fill))
      FILL_SIGN: dout = sx << off;
      FILL_KEEP: dout = (old & ~(fm << off)) | (zx << off);
      default:   dout = zx << off;
    endcase
  end
endmodule

// File: rtl/subdw_sel_unit.sv
`timescale 1ns/1ps
module subdw_sel_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] src_a,
  input  logic [DW-1:0] src_b,
  input  logic [2:0]    sel_a,
  input  logic [2:0]    sel_b,
  input  logic          sext_a,
  input  logic          sext_b,
  input  logic [1:0]    alu_op,
  input  logic [2:0]    dst_sel,
  input  logic [1:0]    fill_mode,
  input  logic [DW-1:0] dst_old,
  output logic          out_valid,
  output logic [DW-1:0] result
);
  import subdw_pkg::*;
  localparam int LW = DW / 4;
  localparam int HW = DW / 2;

  logic [DW-1:0] ext_a, ext_b, alu_res, ins_res;

  subdw_extract #(.DW(DW)) u_ext_a (
    .din(src_a), .sel(sel_a), .sext(sext_a), .dout(ext_a)
  );

  subdw_extract #(.DW(DW)) u_ext_b (
    .din(src_b), .sel(sel_b), .sext(sext_b), .dout(ext_b)
  );

  subdw_alu #(.DW(DW)) u_alu (
    .opa(ext_a), .opb(ext_b), .op(alu_op), .res(alu_res)
  );

  subdw_insert #(.DW(DW)) u_ins (
    .res(alu_res), .old(dst_old), .dsel(dst_sel), .fill(fill_mode), .dout(ins_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= ins_res;
    end
  end

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> out_valid == $past(in_valid));

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_full_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sel_a >= 3'd6 && sel_b >= 3'd6 && alu_op == 2'd2 && dst_sel >= 3'd6)
    |=> result == $past(src_a & src_b));

  p_keep_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill_mode == 2'd2 && dst_sel == 3'd0)
    |=> result[DW-1:LW] == $past(dst_old[DW-1:LW]));

  p_zero_low_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fill_mode == 2'd0 && dst_sel == 3'd5)
    |=> result[HW-1:0] == '0);
endmodule

// File: tb/subdw_sel_unit_bench.sv
`timescale 1ns/1ps
module subdw_sel_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [2:0]  sel_a = '0, sel_b = '0, dst_sel = '0;
  logic        sext_a = 1'b0, sext_b = 1'b0;
  logic [1:0]  alu_op = '0, fill_mode = '0;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int fails  = 0;
  logic [31:0] held = '0;

  always #2.5 clk = ~clk;

  subdw_sel_unit u_subdw_sel_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .src_a(src_a), .src_b(src_b), .sel_a(sel_a), .sel_b(sel_b),
    .sext_a(sext_a), .sext_b(sext_b), .alu_op(alu_op),
    .dst_sel(dst_sel), .fill_mode(fill_mode), .dst_old(dst_old),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] pick(logic [31:0] v, int s, bit sx);
    int w, o;
    logic [31:0] m, f;
    if (s >= 6) return v;
    if (s < 4) begin w = 8; o = 8 * s; end
    else begin w = 16; o = 16 * (s - 4); end
    m = (32'h1 << w) - 1;
    f = (v >> o) & m;
    if (sx && f[w-1]) f = f | ~m;
    return f;
  endfunction

  function automatic logic [31:0] calc(logic [31:0] x, logic [31:0] y, int op);
    if (op == 1) return x + y;
    if (op == 2) return x & y;
    return x ^ y;
  endfunction

  function automatic logic [31:0] place(logic [31:0] r, logic [31:0] old, int s, int fm);
    int w, o;
    logic [31:0] m, f;
    if (s >= 6) return r;
    if (s < 4) begin w = 8; o = 8 * s; end
    else begin w = 16; o = 16 * (s - 4); end
    m = (32'h1 << w) - 1;
    f = r & m;
    if (fm == 1) begin
      if (f[w-1]) f = f | ~m;
      return f << o;
    end
    if (fm == 2) return (old & ~(m << o)) | (f << o);
    return f << o;
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Called at a negedge: drive, wait one cycle, compare at the next negedge.
  task automatic step(string tag, bit v, logic [31:0] a, logic [31:0] b,
                      int sa, int sb, bit xa, bit xb, int op, int ds, int fm,
                      logic [31:0] old);
    logic [31:0] exp;
    in_valid = v; src_a = a; src_b = b;
    sel_a = 3'(sa); sel_b = 3'(sb); sext_a = xa; sext_b = xb;
    alu_op = 2'(op); dst_sel = 3'(ds); fill_mode = 2'(fm); dst_old = old;
    exp = v ? place(calc(pick(a, sa, xa), pick(b, sb, xb), op), old, ds, fm) : held;
    @(negedge clk);
    check({tag, " valid"}, {31'b0, out_valid}, {31'b0, v});
    check(tag, result, exp);
    held = exp;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] va = 32'h8A7F_C312;
    repeat (3) @(negedge clk);
    check("R11 reset valid", {31'b0, out_valid}, 32'h0);
    check("R11 reset result", result, 32'h0);
    rst = 1'b0;

    // R1 / R2: each field, zero-extended, XOR with zero
    for (int s = 0; s < 6; s++) step("R1", 1, va, 0, s, 6, 0, 0, 0, 6, 0, 0);
    step("R2", 1, va, 0, 1, 6, 0, 0, 0, 6, 0, 0);    // 000000C3
    step("R2", 1, va, 0, 5, 6, 0, 0, 0, 6, 0, 0);    // 00008A7F
    // R3: sign extension from byte and half
    step("R3", 1, va, 0, 1, 6, 1, 0, 0, 6, 0, 0);    // FFFFFFC3
    step("R3", 1, va, 0, 5, 6, 1, 0, 0, 6, 0, 0);    // FFFF8A7F
    step("R3", 1, va, 0, 2, 6, 1, 0, 0, 6, 0, 0);    // 0000007F
    step("R3", 1, 0, 32'h0000_8001, 6, 4, 0, 1, 0, 6, 0, 0);
    // R4: full word and reserved code, flag ignored
    step("R4", 1, va, 0, 6, 6, 1, 1, 0, 6, 0, 0);
    step("R4", 1, va, 32'hFFFF_0000, 7, 7, 1, 1, 2, 7, 1, 32'h1234_5678);
    // R5: ALU functions on widened values
    step("R5", 1, 32'hFFFF_FFFF, 1, 6, 6, 0, 0, 1, 6, 0, 0);   // wrap to 0
    step("R5", 1, va, 32'h0000_0012, 3, 0, 1, 0, 1, 6, 0, 0);  // FFFFFF9C
    step("R5", 1, 32'hF0F0_F0F0, 32'hFF00_FF00, 6, 6, 0, 0, 2, 6, 0, 0);
    step("R5", 1, 32'hF0F0_F0F0, 32'hFF00_FF00, 6, 6, 0, 0, 3, 6, 0, 0);
    // R6 / R7: placement with zero fill
    for (int d = 0; d < 6; d++) step("R6", 1, 32'h0000_B5A6, 0, 6, 6, 0, 0, 0, d, 0, 32'hFFFF_FFFF);
    step("R7", 1, 32'h0000_0081, 0, 6, 6, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    // R8: sign fill, negative and positive fields
    step("R8", 1, 32'h0000_0081, 0, 6, 6, 0, 0, 0, 1, 1, 0);    // FFFF8100
    step("R8", 1, 32'h0000_0071, 0, 6, 6, 0, 0, 0, 2, 1, 0);    // 00710000
    step("R8", 1, 32'h0000_8000, 0, 6, 6, 0, 0, 0, 4, 1, 0);    // FFFF8000
    // R9: keep, and reserved mode as zero
    step("R9", 1, 32'h0000_00AB, 0, 6, 6, 0, 0, 0, 2, 2, 32'h1122_3344);
    step("R9", 1, 32'h0000_BEEF, 0, 6, 6, 0, 0, 0, 5, 2, 32'h1122_3344);
    step("R9", 1, 32'h0000_00AB, 0, 6, 6, 0, 0, 0, 2, 3, 32'h1122_3344);
    // R10: idle cycles hold the result even with changing inputs
    step("R10", 0, 32'hDEAD_BEEF, 32'h1, 6, 6, 0, 0, 1, 6, 0, 0);
    step("R10", 0, 32'h5555_5555, 32'h2, 0, 1, 1, 1, 2, 3, 1, 0);
    step("R10", 1, 32'h0000_0005, 32'h3, 6, 6, 0, 0, 1, 6, 0, 0);
    // R11: reset during a valid input clears the outputs
    in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    check("R11 mid valid", {31'b0, out_valid}, 32'h0);
    check("R11 mid result", result, 32'h0);
    rst = 1'b0; held = '0;
    step("R11 idle", 0, 0, 0, 6, 6, 0, 0, 0, 6, 0, 0);
    // Random stream against the model
    for (int i = 0; i < 400; i++) begin
      step("R6 random", ($urandom % 4) != 0, $urandom, $urandom,
           $urandom % 8, $urandom % 8, $urandom % 2, $urandom % 2,
           $urandom % 4, $urandom % 8, $urandom % 4, $urandom);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule